// File: doc/BRIEF.md
# Set/Clear Aliased Register Bank

This block is a bank of control and status registers for a peripheral. Software can change single bits without a read-modify-write sequence. Each register owns three consecutive word addresses: a set alias, a clear alias and a read alias. A write to the set alias turns on every bit whose write-data bit is one. A write to the clear alias turns off every such bit. A zero in the write data leaves the matching bit alone. The read alias returns the stored value.

The bank's address space starts at offset zero, which is the lowest address of its region. Register `i` takes word offsets `3*i` (set), `3*i+1` (clear) and `3*i+2` (read). The surrounding logic sees every register at once on a flat output bus. It can raise any bit through a per-bit hardware set input, and a hardware set takes priority over a software clear in the same cycle.

The bus is a plain synchronous slave. It has a word address, write data and a write strobe. Read data is registered and is valid one clock after the address is presented. The reset input is asynchronous and active low, and its release is synchronised inside the block over two clocks.

Top module: `scb_bank`

## Requirements
- R1: While reset is held and after it is released, every register and the read data are zero.
- R2: A write to word offset `3*i` ORs the write data into register `i`; bits written as zero keep their value.
- R3: A write to word offset `3*i+1` clears in register `i` every bit written as one; bits written as zero keep their value.
- R4: One clock after the address is word offset `3*i+2`, the read data equals the value register `i` held when that address was sampled.
- R5: One clock after the address is a set or clear alias (offset `3*i` or `3*i+1`), the read data is zero.
- R6: Word offsets at or above `3*NUM_REGS` do nothing on a write and read back as zero.
- R7: A one on a hardware set bit makes that register bit one after the next clock edge, even if software clears the same bit in that cycle.
- R8: A write changes only the one register that the address selects.
- R9: With no write strobe and no hardware set, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset from the bank's base |
| bus_wdata | input | DATA_W | Write data, one bit per register bit |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Registered read data |
| hw_set | input | NUM_REGS*DATA_W | Per-bit set requests from the surrounding logic, register `i` at bits `[i*DATA_W +: DATA_W]` |
| reg_out | output | NUM_REGS*DATA_W | Current contents of all registers, same packing as `hw_set` |

## Verification
Directed cases write dense and sparse masks to each alias of the first and last registers:
- A set followed by a partial clear shows that the OR and AND-NOT paths are separate.
- All-zero masks show that zero bits have no effect.
- A hardware set that collides with a software clear of the same bit checks which source wins.

Random traffic then draws addresses across the whole window and past its top end, mixed with sparse hardware set vectors. A wrong alias offset shows up as a change in the wrong register. A read path that leaks shows up as non-zero data from a write-only alias.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic [1:0] {
    SLOT_SET = 2'd0,
    SLOT_CLR = 2'd1,
    SLOT_RD  = 2'd2
  } slot_e;

  localparam int SLOTS_PER_REG = 3;

  // Word offset of one alias of register idx.
  function automatic int slot_offset(input int idx, input slot_e slot);
    slot_offset = idx * SLOTS_PER_REG + int'(slot);
  endfunction

endpackage

// File: rtl/scb_rst_sync.sv
module scb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;

endmodule

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  output logic [NUM_REGS-1:0] set_sel,
  output logic [NUM_REGS-1:0] clr_sel,
  output logic [NUM_REGS-1:0] rd_sel
);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(slot_offset(gi, SLOT_SET));
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(slot_offset(gi, SLOT_CLR));
    localparam logic [ADDR_W-1:0] RD_A  = ADDR_W'(slot_offset(gi, SLOT_RD));

    always_comb begin
      set_sel[gi] = we && (addr == SET_A);
      clr_sel[gi] = we && (addr == CLR_A);
      rd_sel[gi]  = (addr == RD_A);
    end
  end

endmodule

// File: rtl/scb_cell.sv
module scb_cell #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] q_d;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;
  logic              upd_en;

  // Next state: software clear first, then the hardware set on top of it.
  always_comb begin
    set_mask = set_en ? wdata : '0;
    clr_mask = clr_en ? wdata : '0;
    q_d      = ((q_r | set_mask) & ~clr_mask) | hw_set;
    upd_en   = set_en || clr_en || (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd_en) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/scb_rdmux.sv
module scb_rdmux #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16
) (
  input  logic [NUM_REGS-1:0]        rd_sel,
  input  logic [NUM_REGS*DATA_W-1:0] regs,
  output logic [DATA_W-1:0]          data
);

  // AND-OR select; an unselected or write-only address yields zero.
  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      data = data | (regs[i*DATA_W +: DATA_W] & {DATA_W{rd_sel[i]}});
    end
  end

endmodule

// File: rtl/scb_bank.sv
module scb_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_we,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_REGS*DATA_W-1:0] hw_set,
  output logic [NUM_REGS*DATA_W-1:0] reg_out
);

  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic                rst_q_n;
  logic [NUM_REGS-1:0] set_sel;
  logic [NUM_REGS-1:0] clr_sel;
  logic [NUM_REGS-1:0] rd_sel;
  logic [FLAT_W-1:0]   regs_flat;
  logic [DATA_W-1:0]   rdata_d;
  logic [DATA_W-1:0]   rdata_q;

  scb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  scb_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr    (bus_addr),
    .we      (bus_we),
    .set_sel (set_sel),
    .clr_sel (clr_sel),
    .rd_sel  (rd_sel)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    scb_cell #(
      .DATA_W (DATA_W)
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .set_en (set_sel[gi]),
      .clr_en (clr_sel[gi]),
      .wdata  (bus_wdata),
      .hw_set (hw_set[gi*DATA_W +: DATA_W]),
      .q      (regs_flat[gi*DATA_W +: DATA_W])
    );
  end

  scb_rdmux #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_rd (
    .rd_sel (rd_sel),
    .regs   (regs_flat),
    .data   (rdata_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign reg_out   = regs_flat;

endmodule

// File: rtl/scb_bank_chk.sv
module scb_bank_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 6
) (
  input logic                       clk,
  input logic                       rst_q_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       bus_we,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_REGS*DATA_W-1:0] hw_set,
  input logic [NUM_REGS*DATA_W-1:0] reg_out,
  input logic [NUM_REGS-1:0]        set_sel,
  input logic [NUM_REGS-1:0]        clr_sel,
  input logic [NUM_REGS-1:0]        rd_sel
);

  function automatic logic [DATA_W-1:0] word_of(input logic [NUM_REGS*DATA_W-1:0] v,
                                                input int idx);
    word_of = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (k == idx) word_of = v[k*DATA_W +: DATA_W];
    end
  endfunction

  int          reg_idx;
  int          slot_kind;
  logic        in_range;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] cur_hw;

  always_comb begin
    reg_idx   = int'(bus_addr) / 3;
    slot_kind = int'(bus_addr) % 3;
    in_range  = reg_idx < NUM_REGS;
    cur_word  = word_of(reg_out, reg_idx);
    cur_hw    = word_of(hw_set, reg_idx);
  end

  // R2: set alias turns on every written one
  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && in_range && slot_kind == 0)
    |=> ((word_of(reg_out, $past(reg_idx)) & $past(bus_wdata)) == $past(bus_wdata)));

  // R3 and R7: cleared bits are zero unless hardware set them in the same cycle
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && in_range && slot_kind == 1)
    |=> ((word_of(reg_out, $past(reg_idx)) & $past(bus_wdata) & ~$past(cur_hw)) == '0));

  // R4: read alias returns the stored value one cycle later
  assert_read_back_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_range && slot_kind == 2) |=> (bus_rdata == $past(cur_word)));

  // R5 and R6: every address other than a read alias reads zero
  assert_rd_zero_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!in_range || slot_kind != 2) |=> (bus_rdata == '0));

  // R7: a hardware set always lands
  assert_hw_wins_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|hw_set) |=> ((reg_out & $past(hw_set)) == $past(hw_set)));

  // R8: decode selects at most one alias
  assert_one_slot_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({set_sel, clr_sel, rd_sel}));

  // R9: quiet cycles hold the registers
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bus_we && hw_set == '0) |=> $stable(reg_out));

endmodule

bind scb_bank scb_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .hw_set    (hw_set),
  .reg_out   (reg_out),
  .set_sel   (set_sel),
  .clr_sel   (clr_sel),
  .rd_sel    (rd_sel)
);

// File: tb/scb_bank_tb.sv
module scb_bank_tb;

  localparam int NR = 4;
  localparam int DW = 16;
  localparam int AW = 6;

  logic              clk;
  logic              rst_n;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_wdata;
  logic              bus_we;
  logic [DW-1:0]     bus_rdata;
  logic [NR*DW-1:0]  hw_set;
  logic [NR*DW-1:0]  reg_out;

  logic [DW-1:0] mdl [NR];
  int n_chk;
  int n_bad;
  bit finished;

  scb_bank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .hw_set    (hw_set),
    .reg_out   (reg_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [NR*DW-1:0] flat_model();
    for (int i = 0; i < NR; i++) flat_model[i*DW +: DW] = mdl[i];
  endfunction

  // Expected read data for an address, from the model before the edge.
  function automatic logic [DW-1:0] exp_read(input int a);
    if (a < 3 * NR && a % 3 == 2) exp_read = mdl[a / 3];
    else exp_read = '0;
  endfunction

  task automatic check(input string req, input logic [NR*DW-1:0] act,
                       input logic [NR*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, model the edge, check at next negedge.
  task automatic step(input int a, input logic [DW-1:0] wd, input logic we,
                      input logic [NR*DW-1:0] hw, input string wr_req, input string rd_req);
    logic [DW-1:0] rd_exp;
    bus_addr  = AW'(a);
    bus_wdata = wd;
    bus_we    = we;
    hw_set    = hw;
    rd_exp    = exp_read(a);
    for (int i = 0; i < NR; i++) begin
      if (we && a == 3 * i)     mdl[i] = mdl[i] | wd;
      if (we && a == 3 * i + 1) mdl[i] = mdl[i] & ~wd;
      mdl[i] = mdl[i] | hw[i*DW +: DW];
    end
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    hw_set = '0;
    check(wr_req, reg_out, flat_model());
    check(rd_req, {{(NR-1)*DW{1'b0}}, bus_rdata}, {{(NR-1)*DW{1'b0}}, rd_exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    seed_dummy = $urandom(32'h5eed_c1a5);
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    rst_n = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    bus_we = 1'b0;
    hw_set = '0;
    repeat (3) @(negedge clk);
    check("R1", reg_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", reg_out, '0);
    check("R1", {{(NR-1)*DW{1'b0}}, bus_rdata}, '0);

    // Directed corner cases
    step(0, 16'hA5A5, 1'b1, '0, "R2", "R5");
    step(2, 16'h0000, 1'b0, '0, "R9", "R4");
    step(1, 16'h00F0, 1'b1, '0, "R3", "R5");
    step(2, 16'hFFFF, 1'b0, '0, "R9", "R4");
    step(0, 16'h0000, 1'b1, '0, "R2", "R5");
    step(1, 16'h0000, 1'b1, '0, "R3", "R5");
    step(2, 16'h0000, 1'b0, '0, "R3", "R4");
    step(9, 16'hFFFF, 1'b1, '0, "R8", "R5");
    step(11, 16'h0000, 1'b0, '0, "R8", "R4");
    step(10, 16'h0008, 1'b1, {16'h0008, {(NR-1)*DW{1'b0}}}, "R7", "R5");
    step(4, 16'h8001, 1'b1, {{(NR-2)*DW{1'b0}}, 16'h8000, 16'h0}, "R7", "R5");
    step(12, 16'hFFFF, 1'b1, '0, "R6", "R6");
    step(14, 16'h0000, 1'b0, '0, "R6", "R6");
    step(3, 16'h1234, 1'b1, '0, "R8", "R5");
    step(5, 16'h0000, 1'b0, '0, "R9", "R4");

    // Constrained random traffic
    for (int n = 0; n < 600; n++) begin
      int a;
      logic we;
      logic [DW-1:0] wd;
      logic [NR*DW-1:0] hw;
      string wr_req;
      string rd_req;
      a  = int'($urandom % 16);
      we = ($urandom % 3) != 0;
      wd = DW'($urandom);
      hw = '0;
      if ($urandom % 4 == 0) begin
        for (int i = 0; i < NR; i++) hw[i*DW +: DW] = DW'($urandom & $urandom & $urandom);
      end
      if (hw != '0)            wr_req = "R7";
      else if (!we)            wr_req = "R9";
      else if (a >= 3 * NR)    wr_req = "R6";
      else if (a % 3 == 0)     wr_req = "R2";
      else if (a % 3 == 1)     wr_req = "R3";
      else                     wr_req = "R8";
      if (a >= 3 * NR)         rd_req = "R6";
      else if (a % 3 == 2)     rd_req = "R4";
      else                     rd_req = "R5";
      step(a, wd, we, hw, wr_req, rd_req);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule